// File: doc/BRIEF.md
# Double-Trigger ADC Scan Sequencer

This block is the control side of a successive-approximation ADC front end, working in a single-scan mode where each hardware trigger converts one channel. A 5-bit channel field selects that channel. Triggers are taken in pairs. The first trigger of a pair converts the channel and writes the result into that channel's own result register. The second trigger converts the same channel again and writes the result only into a separate duplicate register. The scan-complete interrupt is raised only at the end of the second conversion.

The analog conversion is done by an external converter core. The sequencer talks to it through a start/channel/done/data handshake. Only the synchronous hardware trigger can start a conversion. The mode enable and the trigger enable must both be set, and the external-pin trigger select must be clear. A busy flag is high for the whole of each conversion, and a one-cycle interrupt pulse marks the end of a pair.

Top module: `dtrig_adc_seq`

## Requirements
- R1: After reset, `busy`, `conv_start` and `scan_irq` are 0, and every channel result register and the duplicate register hold 0.
- R2: A rising edge of `clk` that samples `sync_trig`=1 starts a conversion only when `cfg_dbl_en`=1, `cfg_trig_en`=1, `cfg_pin_trig_sel`=0 and the block is not busy. Otherwise `conv_start` and `busy` stay 0.
- R3: An accepted trigger raises `busy` and a one-cycle `conv_start` on the next clock edge. On the first trigger of a pair, `conv_ch` takes the value of `cfg_dbl_ch`, and it holds that value while `busy` is 1.
- R4: When the first conversion of a pair ends, the edge that samples `conv_done`=1 does three things: it writes `conv_data` into the result register of the converted channel (bits [12*c+11:12*c] of `res_flat` for channel c), it clears `busy`, and it raises no interrupt, whatever `cfg_irq_en` is.
- R5: The second accepted trigger converts the channel that was latched by the first trigger, even if `cfg_dbl_ch` has changed since. Its result goes only to `dup_res`, and every channel result register stays unchanged.
- R6: On the edge that ends the second conversion, `busy` clears. On that same edge, `scan_irq` goes to 1 for exactly one cycle if `cfg_irq_en` was 1, and stays 0 if it was 0.
- R7: A trigger that arrives while `busy` is 1 is ignored. It produces no `conv_start` and does not move the pair from its first half to its second.
- R8: While idle, setting `cfg_dbl_en` or `cfg_trig_en` to 0 returns the pair tracking to its first half. The next accepted trigger then writes a channel register, not `dup_res`.
- R9: A `conv_done` pulse while the block is idle changes no register and raises neither `busy` nor `scan_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbl_en | input | 1 | Double-trigger mode enable |
| cfg_dbl_ch | input | 5 | Channel to convert in double-trigger mode |
| cfg_irq_en | input | 1 | Scan-complete interrupt enable |
| cfg_trig_en | input | 1 | Hardware trigger enable |
| cfg_pin_trig_sel | input | 1 | External-pin trigger selected (blocks synchronous starts) |
| sync_trig | input | 1 | Synchronous hardware trigger |
| conv_start | output | 1 | One-cycle start request to the converter core |
| conv_ch | output | 5 | Channel for the converter core |
| conv_done | input | 1 | Converter core completion strobe |
| conv_data | input | 12 | Converter core result |
| res_flat | output | 384 | Per-channel result registers, channel c at bits [12c+11:12c] |
| dup_res | output | 12 | Duplicate result register |
| busy | output | 1 | Conversion in progress (start/busy status) |
| scan_irq | output | 1 | Scan-complete interrupt pulse |

## Verification
Seeded random pairs vary the channel, the interrupt enable, and whether `cfg_dbl_ch` is changed between the two triggers. Changing it between triggers shows whether the channel is latched for the whole pair or read again at the second trigger. Directed cases cover four other situations: triggers blocked by each gating input, a trigger during busy (which must not advance the pair), a mode drop between triggers (which must restart the pair), and a stray completion strobe while idle. Comparing the full register bank after every conversion shows a result written to the wrong place, whether that is the wrong channel register or the wrong choice between a channel register and the duplicate register.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dtrig_trig_qual.sv
module dtrig_trig_qual (
  input  logic sync_trig,
  input  logic dbl_en,
  input  logic trig_en,
  input  logic pin_sel,
  input  logic idle,
  output logic accept,
  output logic phase_clr
);
  logic path_ok;

  always_comb begin
    path_ok   = dbl_en & trig_en & ~pin_sel;
    accept    = sync_trig & path_ok & idle;
    phase_clr = ~(dbl_en & trig_en);
  end
endmodule

// File: rtl/dtrig_phase_ctrl.sv
module dtrig_phase_ctrl
  import dtrig_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            phase_clr,
  input  logic            irq_en,
  input  logic [CH_W-1:0] sel_ch,
  input  logic            conv_done,
  output logic            idle,
  output logic            busy,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            scan_irq,
  output logic            wr_ch_en,
  output logic            wr_dup_en
);
  seq_state_e      st_q, st_d;
  logic            second_q, second_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            start_q, start_d;
  logic            irq_q, irq_d;
  logic            fin;

  always_comb begin
    st_d     = st_q;
    second_d = second_q;
    ch_d     = ch_q;
    start_d  = 1'b0;
    irq_d    = 1'b0;
    fin      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_CONV;
          start_d = 1'b1;
          if (!second_q) ch_d = sel_ch;
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          st_d     = ST_IDLE;
          fin      = 1'b1;
          second_d = ~second_q;
          irq_d    = second_q & irq_en;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (phase_clr && st_q == ST_IDLE) second_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      second_q <= 1'b0;
      ch_q     <= '0;
      start_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      second_q <= second_d;
      ch_q     <= ch_d;
      start_q  <= start_d;
      irq_q    <= irq_d;
    end
  end

  always_comb begin
    idle       = (st_q == ST_IDLE);
    busy       = (st_q == ST_CONV);
    conv_start = start_q;
    conv_ch    = ch_q;
    scan_irq   = irq_q;
    wr_ch_en   = fin & ~second_q;
    wr_dup_en  = fin & second_q;
  end
endmodule

// File: rtl/dtrig_result_bank.sv
module dtrig_result_bank #(
  parameter int NUM_CH = 32,
  parameter int CH_W   = 5,
  parameter int RES_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_ch_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic                    wr_dup_en,
  input  logic [RES_W-1:0]        wr_data,
  output logic [NUM_CH*RES_W-1:0] res_flat,
  output logic [RES_W-1:0]        dup_res
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [RES_W-1:0] r_q;
    logic             hit;
    always_comb hit = wr_ch_en && (wr_ch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r_q <= '0;
      else if (hit) r_q <= wr_data;
    end
    assign res_flat[g*RES_W +: RES_W] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dup_res <= '0;
    else if (wr_dup_en) dup_res <= wr_data;
  end
endmodule

// File: rtl/dtrig_adc_seq.sv
module dtrig_adc_seq #(
  parameter int NUM_CH = 32,
  parameter int RES_W  = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_dbl_en,
  input  logic [CH_W-1:0]         cfg_dbl_ch,
  input  logic                    cfg_irq_en,
  input  logic                    cfg_trig_en,
  input  logic                    cfg_pin_trig_sel,
  input  logic                    sync_trig,
  output logic                    conv_start,
  output logic [CH_W-1:0]         conv_ch,
  input  logic                    conv_done,
  input  logic [RES_W-1:0]        conv_data,
  output logic [NUM_CH*RES_W-1:0] res_flat,
  output logic [RES_W-1:0]        dup_res,
  output logic                    busy,
  output logic                    scan_irq
);
  logic accept, phase_clr, idle, wr_ch_en, wr_dup_en;

  dtrig_trig_qual u_qual (
    .sync_trig (sync_trig),
    .dbl_en    (cfg_dbl_en),
    .trig_en   (cfg_trig_en),
    .pin_sel   (cfg_pin_trig_sel),
    .idle      (idle),
    .accept    (accept),
    .phase_clr (phase_clr)
  );

  dtrig_phase_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .phase_clr  (phase_clr),
    .irq_en     (cfg_irq_en),
    .sel_ch     (cfg_dbl_ch),
    .conv_done  (conv_done),
    .idle       (idle),
    .busy       (busy),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .scan_irq   (scan_irq),
    .wr_ch_en   (wr_ch_en),
    .wr_dup_en  (wr_dup_en)
  );

  dtrig_result_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ch_en  (wr_ch_en),
    .wr_ch     (conv_ch),
    .wr_dup_en (wr_dup_en),
    .wr_data   (conv_data),
    .res_flat  (res_flat),
    .dup_res   (dup_res)
  );
endmodule

// File: rtl/dtrig_adc_seq_chk.sv
module dtrig_adc_seq_chk #(
  parameter int CH_W  = 5,
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dbl_en,
  input logic             cfg_irq_en,
  input logic             cfg_trig_en,
  input logic             cfg_pin_trig_sel,
  input logic             sync_trig,
  input logic             conv_start,
  input logic [CH_W-1:0]  conv_ch,
  input logic             busy,
  input logic             scan_irq,
  input logic [RES_W-1:0] dup_res
);
  AST_START_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(sync_trig && cfg_dbl_en && cfg_trig_en && !cfg_pin_trig_sel)); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R3
  AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(conv_ch)); // R3
  AST_DUP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dup_res) |-> $fell(busy)); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |=> !scan_irq); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |-> ($past(cfg_irq_en) && $fell(busy))); // R6
endmodule

bind dtrig_adc_seq dtrig_adc_seq_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_dbl_en       (cfg_dbl_en),
  .cfg_irq_en       (cfg_irq_en),
  .cfg_trig_en      (cfg_trig_en),
  .cfg_pin_trig_sel (cfg_pin_trig_sel),
  .sync_trig        (sync_trig),
  .conv_start       (conv_start),
  .conv_ch          (conv_ch),
  .busy             (busy),
  .scan_irq         (scan_irq),
  .dup_res          (dup_res)
);

// File: tb/dtrig_adc_seq_test.sv
module dtrig_adc_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 32;
  localparam int RES_W  = 12;
  localparam int CH_W   = 5;
  localparam int LAT    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dbl_en = 1'b1, cfg_irq_en = 1'b1, cfg_trig_en = 1'b1, cfg_pin_trig_sel = 1'b0;
  logic [CH_W-1:0] cfg_dbl_ch = '0;
  logic sync_trig = 1'b0;
  logic conv_start, busy, scan_irq, conv_done;
  logic [CH_W-1:0] conv_ch;
  logic [RES_W-1:0] conv_data = '0;
  logic [RES_W-1:0] dup_res;
  logic [NUM_CH*RES_W-1:0] res_flat;
  logic rsp_done = 1'b0, stray_done = 1'b0;

  int n_chk = 0, n_bad = 0;
  int rsp_pend = 0, rsp_seq = 0;
  logic [CH_W-1:0] rsp_ch = '0;
  logic [RES_W-1:0] exp_regs [NUM_CH];
  logic [RES_W-1:0] exp_dup = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign conv_done = rsp_done | stray_done;

  dtrig_adc_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_dbl_en(cfg_dbl_en), .cfg_dbl_ch(cfg_dbl_ch),
    .cfg_irq_en(cfg_irq_en), .cfg_trig_en(cfg_trig_en), .cfg_pin_trig_sel(cfg_pin_trig_sel),
    .sync_trig(sync_trig), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .res_flat(res_flat),
    .dup_res(dup_res), .busy(busy), .scan_irq(scan_irq)
  );

  function automatic logic [RES_W-1:0] make_val(int ch, int seq);
    return RES_W'((ch * 151 + seq * 37 + 9) % 4096);
  endfunction

  // fixed-latency converter model
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_pend = 0;
      rsp_done = 1'b0;
    end else begin
      rsp_done = 1'b0;
      if (rsp_pend > 0) begin
        rsp_pend--;
        if (rsp_pend == 0) begin
          rsp_done  = 1'b1;
          conv_data = make_val(int'(rsp_ch), rsp_seq);
        end
      end
      if (conv_start) begin
        rsp_pend = LAT;
        rsp_ch   = conv_ch;
        rsp_seq++;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_bank(string req);
    int bad_ch = -1;
    for (int c = 0; c < NUM_CH; c++)
      if (bad_ch < 0 && res_flat[c*RES_W +: RES_W] !== exp_regs[c]) bad_ch = c;
    n_chk++;
    if (bad_ch >= 0) begin
      n_bad++;
      $display("FAIL %s: channel %0d actual %0d expected %0d", req, bad_ch,
               res_flat[bad_ch*RES_W +: RES_W], exp_regs[bad_ch]);
    end
  endtask

  task automatic pulse_trig(string req, bit exp_start, bit exp_busy, int exp_ch);
    @(negedge clk) sync_trig = 1'b1;
    @(negedge clk) sync_trig = 1'b0;
    check({req, " conv_start"}, int'(conv_start), int'(exp_start));
    check({req, " busy"}, int'(busy), int'(exp_busy));
    if (exp_start) check({req, " conv_ch"}, int'(conv_ch), exp_ch);
  endtask

  task automatic wait_idle(output int hits);
    int guard = 0;
    hits = 0;
    while (busy && guard < 100) begin
      @(negedge clk);
      if (scan_irq) hits++;
      guard++;
    end
    @(negedge clk);
    if (scan_irq) hits++;
  endtask

  task automatic do_pair(int ch, bit irq_en, bit chg);
    int hits;
    cfg_dbl_ch = CH_W'(ch);
    cfg_irq_en = irq_en;
    pulse_trig("R3 first", 1'b1, 1'b1, ch);
    wait_idle(hits);
    exp_regs[ch] = make_val(ch, rsp_seq);
    check("R4 no irq after first", hits, 0);
    check("R4 busy cleared", int'(busy), 0);
    check_bank("R4 channel reg written");
    check("R4 dup untouched", int'(dup_res), int'(exp_dup));
    if (chg) cfg_dbl_ch = CH_W'((ch + 7) % NUM_CH);
    pulse_trig("R5 second", 1'b1, 1'b1, ch);
    wait_idle(hits);
    exp_dup = make_val(ch, rsp_seq);
    check("R6 irq count", hits, int'(irq_en));
    check("R5 dup written", int'(dup_res), int'(exp_dup));
    check_bank("R5 channel regs unchanged");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hits;
    void'($urandom(32'd4177));
    for (int c = 0; c < NUM_CH; c++) exp_regs[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 conv_start", int'(conv_start), 0);
    check("R1 scan_irq", int'(scan_irq), 0);
    check("R1 dup", int'(dup_res), 0);
    check_bank("R1 bank");

    // directed pairs: boundary channels, both irq settings
    do_pair(0, 1'b1, 1'b0);
    do_pair(31, 1'b0, 1'b1);

    // R2: each gating input blocks the start
    cfg_dbl_ch = 5'd3;
    cfg_pin_trig_sel = 1'b1;
    pulse_trig("R2 pin select", 1'b0, 1'b0, 0);
    cfg_pin_trig_sel = 1'b0;
    cfg_trig_en = 1'b0;
    pulse_trig("R2 trig disabled", 1'b0, 1'b0, 0);
    cfg_trig_en = 1'b1;
    cfg_dbl_en = 1'b0;
    pulse_trig("R2 mode off", 1'b0, 1'b0, 0);
    cfg_dbl_en = 1'b1;
    @(negedge clk);

    // R7: trigger during busy is ignored and does not advance the pair
    cfg_irq_en = 1'b1;
    pulse_trig("R7 first", 1'b1, 1'b1, 3);
    pulse_trig("R7 during busy", 1'b0, 1'b1, 3);
    wait_idle(hits);
    exp_regs[3] = make_val(3, rsp_seq);
    check("R7 one conversion no irq", hits, 0);
    check_bank("R7 first result");
    pulse_trig("R7 second", 1'b1, 1'b1, 3);
    wait_idle(hits);
    exp_dup = make_val(3, rsp_seq);
    check("R7 dup written", int'(dup_res), int'(exp_dup));
    check("R7 irq", hits, 1);

    // R8: dropping the mode between triggers restarts the pair
    cfg_dbl_ch = 5'd9;
    pulse_trig("R8 first", 1'b1, 1'b1, 9);
    wait_idle(hits);
    exp_regs[9] = make_val(9, rsp_seq);
    cfg_dbl_en = 1'b0;
    @(negedge clk) cfg_dbl_en = 1'b1;
    cfg_dbl_ch = 5'd12;
    pulse_trig("R8 restarted", 1'b1, 1'b1, 12);
    wait_idle(hits);
    exp_regs[12] = make_val(12, rsp_seq);
    check("R8 no irq", hits, 0);
    check("R8 dup untouched", int'(dup_res), int'(exp_dup));
    check_bank("R8 channel reg written");
    cfg_trig_en = 1'b0;
    @(negedge clk) cfg_trig_en = 1'b1;
    pulse_trig("R8 trig_en restart", 1'b1, 1'b1, 12);
    wait_idle(hits);
    exp_regs[12] = make_val(12, rsp_seq);
    check("R8 trig_en no irq", hits, 0);
    check_bank("R8 trig_en channel reg");
    cfg_dbl_en = 1'b0;
    @(negedge clk) cfg_dbl_en = 1'b1;

    // R9: stray completion while idle
    @(negedge clk) begin stray_done = 1'b1; conv_data = 12'hABC; end
    @(negedge clk) stray_done = 1'b0;
    check("R9 busy", int'(busy), 0);
    check("R9 irq", int'(scan_irq), 0);
    check("R9 dup", int'(dup_res), int'(exp_dup));
    check_bank("R9 bank");

    // random pairs
    for (int i = 0; i < 40; i++) begin
      do_pair(int'($urandom % NUM_CH), 1'($urandom % 2), 1'($urandom % 2));
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule